// File: doc/BRIEF.md
# Auxiliary Memory Block Mover

This block copies a block of data between main memory and an auxiliary memory, in either direction. Software programs three values through a 16-bit register interface: a main-memory byte address, an auxiliary-memory byte address, and a length word that also carries the direction bit. Each value is split into a high half and a low half. A write to the low half of the length starts the copy.

Data moves as 64-bit beats of 8 bytes through two simple memory ports. Reads on both ports are combinational, and a write lands on the clock edge while its enable is high. Each beat passes through unchanged. The completion time does not depend on how fast the beats move. It is modelled from the transfer size, and at that time the block drops busy and pulses an interrupt event for the interrupt register. An info register can select a mode in which auxiliary writes below a boundary are also copied into a second region above it.

Top module: `auxBlockMover`

## Requirements
- R1: Register index 0 (main high), 2 (aux high) and 4 (length high) keep only bits 9:0 of a write. Index 4 also keeps bit 15 as the direction bit. Read-back shows the masked value.
- R2: Register indices 1 (main low), 3 (aux low) and 5 (length low) keep only bits 15:5 of a write, so read-back is the written value AND 0xFFE0.
- R3: Index 6 (info) keeps bits 6:0. Index 7 (refresh) keeps bits 10:0 and resets to 156. Index 8 (mode) always reads 1 and ignores writes. After reset, busy and the interrupt pulse are 0.
- R4: A write to index 5 while idle stores the value and starts a transfer. busy reads 1 in the cycle after that write's clock edge.
- R5: With direction bit 1, each beat reads the auxiliary port and writes the same 64-bit word to main memory. With direction bit 0, it reads main memory and writes the auxiliary port. Only one write enable is ever high at a time.
- R6: A transfer of N bytes makes N/8 beats. Each beat advances both addresses by 8, and addresses wrap modulo 2^26, so memory mirrors every 64 MB.
- R7: doneIrq is a one-cycle pulse that is high in the cycle after clock edge E0+T, where E0 is the start edge and T = (N/32)*246. busy falls on that same edge. A zero-length transfer completes at E0+2.
- R8: With info bits 3:0 equal to 4 and direction 0, every beat whose auxiliary address is below 0x400000 first writes its word at that address plus 0x400000, then at the address itself. No such extra write occurs in any other case.
- R9: If the auxiliary start address is at or above the configured auxiliary size (16 MB by default), no beats are made, but completion still follows R7.
- R10: A write to index 5 while busy is ignored. It neither changes the stored value nor starts a transfer, and the running transfer completes at its original time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 4 | Register index |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regIdx (combinational) |
| mainAddr | output | 26 | Main-memory byte address |
| mainWrEn | output | 1 | Main-memory write enable |
| mainWrData | output | 64 | Main-memory write data |
| mainRdData | input | 64 | Main-memory read data for mainAddr |
| auxAddr | output | 26 | Auxiliary-memory byte address |
| auxWrEn | output | 1 | Auxiliary-memory write enable |
| auxWrData | output | 64 | Auxiliary-memory write data |
| auxRdData | input | 64 | Auxiliary-memory read data for auxAddr |
| busy | output | 1 | Transfer in progress |
| doneIrq | output | 1 | One-cycle completion event |

## Verification
Register read-back is combinational, so it is sampled one time step after the index is set. busy must read 1 at the first falling edge after the start edge. The completion pulse is due exactly T rising edges after the start edge. The bench counts rising edges from a free-running cycle counter and compares that count against the size formula. Beat order and timing are only bounded by completion, so a scoreboard queues every expected write in order, and a falling-edge monitor compares each write as it appears. A queue that is not empty once completion is seen counts as a failure.

// File: rtl/auxMovePkg.sv
package auxMovePkg;
  localparam logic [3:0] IDX_MAIN_HI = 4'd0;
  localparam logic [3:0] IDX_MAIN_LO = 4'd1;
  localparam logic [3:0] IDX_AUX_HI  = 4'd2;
  localparam logic [3:0] IDX_AUX_LO  = 4'd3;
  localparam logic [3:0] IDX_LEN_HI  = 4'd4;
  localparam logic [3:0] IDX_LEN_LO  = 4'd5;
  localparam logic [3:0] IDX_INFO    = 4'd6;
  localparam logic [3:0] IDX_REFRESH = 4'd7;
  localparam logic [3:0] IDX_MODE    = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch programmed addresses and length
    logic beatWr;    // primary write of one beat, then advance
    logic mirrorWr;  // extra auxiliary write into the upper region
  } moveStrobe_t;
endpackage

// File: rtl/auxRegBank.sv
module auxRegBank
  import auxMovePkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int COUNT_W = 26
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [3:0]           idx,
  input  logic [15:0]          wrData,
  input  logic                 busy,
  output logic [15:0]          rdData,
  output logic                 startReq,
  output logic [ADDR_W-1:0]    mainBase,
  output logic [ADDR_W-1:0]    auxBase,
  output logic [COUNT_W-6:0]   chunkCount,
  output logic                 dirAuxToMain,
  output logic [3:0]           infoMode
);
  localparam int AHI_W = ADDR_W - 16;
  localparam int CHI_W = COUNT_W - 16;

  logic [AHI_W-1:0] mainHi, auxHi;
  logic [CHI_W-1:0] lenHi;
  logic [10:0]      mainLo, auxLo, lenLo;
  logic             dirBit;
  logic [6:0]       info;
  logic [10:0]      refresh;

  assign startReq = wrEn && (idx == IDX_LEN_LO) && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainHi <= '0; auxHi <= '0; lenHi <= '0;
      mainLo <= '0; auxLo <= '0; lenLo <= '0;
      dirBit <= 1'b0; info <= '0; refresh <= 11'd156;
    end else if (wrEn) begin
      case (idx)
        IDX_MAIN_HI: mainHi <= wrData[AHI_W-1:0];
        IDX_MAIN_LO: mainLo <= wrData[15:5];
        IDX_AUX_HI:  auxHi  <= wrData[AHI_W-1:0];
        IDX_AUX_LO:  auxLo  <= wrData[15:5];
        IDX_LEN_HI: begin
          lenHi  <= wrData[CHI_W-1:0];
          dirBit <= wrData[15];
        end
        IDX_LEN_LO:  if (!busy) lenLo <= wrData[15:5];
        IDX_INFO:    info    <= wrData[6:0];
        IDX_REFRESH: refresh <= wrData[10:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_MAIN_HI: rdData = 16'(mainHi);
      IDX_MAIN_LO: rdData = {mainLo, 5'b0};
      IDX_AUX_HI:  rdData = 16'(auxHi);
      IDX_AUX_LO:  rdData = {auxLo, 5'b0};
      IDX_LEN_HI:  rdData = 16'(lenHi) | {dirBit, 15'b0};
      IDX_LEN_LO:  rdData = {lenLo, 5'b0};
      IDX_INFO:    rdData = 16'(info);
      IDX_REFRESH: rdData = 16'(refresh);
      IDX_MODE:    rdData = 16'd1;
      default:     rdData = 16'd0;
    endcase
  end

  assign mainBase     = {mainHi, mainLo, 5'b0};
  assign auxBase      = {auxHi, auxLo, 5'b0};
  assign chunkCount   = {lenHi, lenLo};
  assign dirAuxToMain = dirBit;
  assign infoMode     = info[3:0];

  // length low half stays frozen while a transfer runs
  assert_len_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lenLo));
  // high halves never show bits above the writable field
  assert_hi_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    (idx == IDX_MAIN_HI || idx == IDX_AUX_HI) |-> rdData[15:AHI_W] == '0);
endmodule

// File: rtl/auxMoveCtrl.sv
module auxMoveCtrl
  import auxMovePkg::*;
#(
  parameter int COUNT_W       = 26,
  parameter int CYC_PER_CHUNK = 246
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [COUNT_W-6:0] chunkCount,
  input  logic               moreBeats,
  input  logic               needMirror,
  output moveStrobe_t        strobe,
  output logic               busy,
  output logic               doneIrq
);
  localparam int CHUNK_W = COUNT_W - 5;
  localparam int TIMER_W = CHUNK_W + $clog2(CYC_PER_CHUNK + 1);

  logic               pending, mirrorDone;
  logic [TIMER_W-1:0] timer, fullTime, loadTime;

  assign fullTime = TIMER_W'(chunkCount) * TIMER_W'(CYC_PER_CHUNK);
  assign loadTime = (fullTime == '0) ? '0 : fullTime - 1'b1;

  logic active;
  assign active          = busy && !pending && moreBeats;
  assign strobe.load     = pending;
  assign strobe.mirrorWr = active && needMirror && !mirrorDone;
  assign strobe.beatWr   = active && !(needMirror && !mirrorDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; pending <= 1'b0; mirrorDone <= 1'b0;
      timer <= '0; doneIrq <= 1'b0;
    end else begin
      doneIrq <= 1'b0;
      if (startReq) begin
        busy <= 1'b1; pending <= 1'b1; mirrorDone <= 1'b0;
      end else if (pending) begin
        pending <= 1'b0;
        timer   <= loadTime;
      end else if (busy) begin
        if (strobe.mirrorWr)    mirrorDone <= 1'b1;
        else if (strobe.beatWr) mirrorDone <= 1'b0;
        if (timer <= TIMER_W'(1)) begin
          busy    <= 1'b0;
          doneIrq <= 1'b1;
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end

  assert_irq_ends_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneIrq);
  assert_beats_before_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !moreBeats);
  assert_no_beat_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(strobe.beatWr || strobe.mirrorWr));
  assert_start_raises_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busy);
endmodule

// File: rtl/auxMoveDatapath.sv
module auxMoveDatapath
  import auxMovePkg::*;
#(
  parameter int              ADDR_W      = 26,
  parameter int              COUNT_W     = 26,
  parameter int              DATA_W      = 64,
  parameter longint unsigned AUX_SIZE    = 64'h100_0000,
  parameter longint unsigned MIRROR_OFFS = 64'h40_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  moveStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  mainBase,
  input  logic [ADDR_W-1:0]  auxBase,
  input  logic [COUNT_W-6:0] chunkCount,
  input  logic               dirAuxToMain,
  input  logic [3:0]         infoMode,
  output logic               moreBeats,
  output logic               needMirror,
  output logic [ADDR_W-1:0]  mainAddr,
  output logic               mainWrEn,
  output logic [DATA_W-1:0]  mainWrData,
  input  logic [DATA_W-1:0]  mainRdData,
  output logic [ADDR_W-1:0]  auxAddr,
  output logic               auxWrEn,
  output logic [DATA_W-1:0]  auxWrData,
  input  logic [DATA_W-1:0]  auxRdData
);
  localparam int                BEAT_W   = COUNT_W - 3;
  localparam int                BEAT_B   = DATA_W / 8;
  localparam logic [ADDR_W-1:0] OFFS     = ADDR_W'(MIRROR_OFFS);

  logic [ADDR_W-1:0] curMain, curAux;
  logic [BEAT_W-1:0] beatsLeft;
  logic              dirLatched, mirrorMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMain <= '0; curAux <= '0; beatsLeft <= '0;
      dirLatched <= 1'b0; mirrorMode <= 1'b0;
    end else if (strobe.load) begin
      curMain    <= mainBase;
      curAux     <= auxBase;
      dirLatched <= dirAuxToMain;
      mirrorMode <= (infoMode == 4'd4) && !dirAuxToMain;
      beatsLeft  <= (64'(auxBase) < AUX_SIZE) ? {chunkCount, 2'b00} : '0;
    end else if (strobe.beatWr) begin
      curMain   <= curMain + ADDR_W'(BEAT_B);
      curAux    <= curAux + ADDR_W'(BEAT_B);
      beatsLeft <= beatsLeft - 1'b1;
    end
  end

  assign moreBeats  = beatsLeft != '0;
  assign needMirror = mirrorMode && (curAux < OFFS);

  assign mainAddr   = curMain;
  assign auxAddr    = strobe.mirrorWr ? curAux + OFFS : curAux;
  assign mainWrEn   = strobe.beatWr && dirLatched;
  assign auxWrEn    = (strobe.beatWr || strobe.mirrorWr) && !dirLatched;
  assign mainWrData = auxRdData;
  assign auxWrData  = mainRdData;

  assert_wr_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mainWrEn, auxWrEn}));
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beatWr |=> mainAddr == $past(mainAddr) + ADDR_W'(BEAT_B));
  assert_mirror_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mirrorWr |-> (auxWrEn && !mainWrEn && auxAddr >= OFFS));
endmodule

// File: rtl/auxBlockMover.sv
module auxBlockMover
  import auxMovePkg::*;
#(
  parameter int              ADDR_W        = 26,
  parameter int              COUNT_W       = 26,
  parameter int              DATA_W        = 64,
  parameter int              CYC_PER_CHUNK = 246,
  parameter longint unsigned AUX_SIZE      = 64'h100_0000,
  parameter longint unsigned MIRROR_OFFS   = 64'h40_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regIdx,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic [ADDR_W-1:0] mainAddr,
  output logic              mainWrEn,
  output logic [DATA_W-1:0] mainWrData,
  input  logic [DATA_W-1:0] mainRdData,
  output logic [ADDR_W-1:0] auxAddr,
  output logic              auxWrEn,
  output logic [DATA_W-1:0] auxWrData,
  input  logic [DATA_W-1:0] auxRdData,
  output logic              busy,
  output logic              doneIrq
);
  moveStrobe_t        strobe;
  logic               startReq, dirAuxToMain, moreBeats, needMirror;
  logic [ADDR_W-1:0]  mainBase, auxBase;
  logic [COUNT_W-6:0] chunkCount;
  logic [3:0]         infoMode;

  auxRegBank #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .idx(regIdx), .wrData(regWrData),
    .busy(busy), .rdData(regRdData), .startReq(startReq),
    .mainBase(mainBase), .auxBase(auxBase), .chunkCount(chunkCount),
    .dirAuxToMain(dirAuxToMain), .infoMode(infoMode));

  auxMoveCtrl #(.COUNT_W(COUNT_W), .CYC_PER_CHUNK(CYC_PER_CHUNK)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chunkCount(chunkCount),
    .moreBeats(moreBeats), .needMirror(needMirror), .strobe(strobe),
    .busy(busy), .doneIrq(doneIrq));

  auxMoveDatapath #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .DATA_W(DATA_W),
                    .AUX_SIZE(AUX_SIZE), .MIRROR_OFFS(MIRROR_OFFS)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mainBase(mainBase),
    .auxBase(auxBase), .chunkCount(chunkCount), .dirAuxToMain(dirAuxToMain),
    .infoMode(infoMode), .moreBeats(moreBeats), .needMirror(needMirror),
    .mainAddr(mainAddr), .mainWrEn(mainWrEn), .mainWrData(mainWrData),
    .mainRdData(mainRdData), .auxAddr(auxAddr), .auxWrEn(auxWrEn),
    .auxWrData(auxWrData), .auxRdData(auxRdData));
endmodule

// File: tb/sim_auxBlockMover.sv
`timescale 1ns/1ps
module sim_auxBlockMover;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regIdx = 4'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic [25:0] mainAddr, auxAddr;
  logic        mainWrEn, auxWrEn, busy, doneIrq;
  logic [63:0] mainWrData, auxWrData, mainRdData, auxRdData;

  always #5 clk = ~clk;

  function automatic logic [63:0] mainPat(logic [25:0] a);
    return {6'h0, a, 6'h0, a} ^ 64'h0123_4567_89AB_CDEF;
  endfunction
  function automatic logic [63:0] auxPat(logic [25:0] a);
    return {a, 6'h0, a, 6'h0} ^ 64'hFEDC_BA98_7654_3210;
  endfunction
  assign mainRdData = mainPat(mainAddr);
  assign auxRdData  = auxPat(auxAddr);

  auxBlockMover u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData),
    .mainAddr(mainAddr), .mainWrEn(mainWrEn), .mainWrData(mainWrData),
    .mainRdData(mainRdData), .auxAddr(auxAddr), .auxWrEn(auxWrEn),
    .auxWrData(auxWrData), .auxRdData(auxRdData), .busy(busy), .doneIrq(doneIrq));

  typedef struct {
    bit          isAux;
    logic [25:0] addr;
    logic [63:0] data;
    string       tag;
  } wrItem_t;
  wrItem_t expQ[$];

  int checks = 0, fails = 0, cyc = 0, startCyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compare every memory write against the scoreboard
  always @(negedge clk) begin
    if (rstN && (mainWrEn || auxWrEn)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected write addr", auxWrEn ? 64'(auxAddr) : 64'(mainAddr), 64'h0);
      end else begin
        wrItem_t e;
        e = expQ.pop_front();
        check(auxWrEn == e.isAux, e.tag, "write port", 64'(auxWrEn), 64'(e.isAux));
        check((auxWrEn ? auxAddr : mainAddr) == e.addr, e.tag, "write addr",
              64'(auxWrEn ? auxAddr : mainAddr), 64'(e.addr));
        check((auxWrEn ? auxWrData : mainWrData) == e.data, e.tag, "write data",
              auxWrEn ? auxWrData : mainWrData, e.data);
      end
    end
  end

  task automatic regWrite(logic [3:0] idx, logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regIdx = idx; regWrData = val;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic regCheck(logic [3:0] idx, logic [15:0] exp, string tag);
    @(negedge clk);
    regIdx = idx;
    #1 check(regRdData == exp, tag, "reg read", 64'(regRdData), 64'(exp));
  endtask

  // driver: program a transfer and push its expected writes
  task automatic launch(logic [25:0] mainA, logic [25:0] auxA, int len, bit dir,
                        logic [3:0] info, bit inRange, string tag);
    regWrite(4'd0, 16'(mainA >> 16));
    regWrite(4'd1, mainA[15:0]);
    regWrite(4'd2, 16'(auxA >> 16));
    regWrite(4'd3, auxA[15:0]);
    regWrite(4'd6, 16'(info));
    regWrite(4'd4, {dir, 5'b0, 10'(len >> 16)});
    if (inRange) begin
      for (int b = 0; b < len / 8; b++) begin
        logic [25:0] m, a;
        m = mainA + 26'(8 * b);
        a = auxA + 26'(8 * b);
        if (dir) expQ.push_back('{1'b0, m, auxPat(a), tag});
        else begin
          if (info == 4'd4 && a < 26'h40_0000)
            expQ.push_back('{1'b1, a + 26'h40_0000, mainPat(m), "R8"});
          expQ.push_back('{1'b1, a, mainPat(m), tag});
        end
      end
    end
    regWrite(4'd5, 16'(len) | 16'h001F);
    startCyc = cyc;
    @(negedge clk);
    check(busy == 1'b1, "R4", "busy after start", 64'(busy), 64'd1);
  endtask

  task automatic waitDone(int expT, string tag);
    int got = -1;
    for (int i = 0; i < expT + 50; i++) begin
      @(negedge clk);
      if (doneIrq) begin
        got = cyc - startCyc;
        break;
      end
    end
    check(got == expT, "R7", {tag, " completion cycle"}, 64'(got), 64'(expT));
    check(busy == 1'b0, "R7", "busy after done", 64'(busy), 64'd0);
    @(negedge clk);
    check(doneIrq == 1'b0, "R7", "pulse width", 64'(doneIrq), 64'd0);
    check(expQ.size() == 0, tag, "missing writes", 64'(expQ.size()), 64'd0);
    expQ.delete();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state R3
    @(negedge clk);
    check(busy == 1'b0 && doneIrq == 1'b0, "R3", "idle after reset", 64'({busy, doneIrq}), 64'd0);
    regCheck(4'd7, 16'd156, "R3");
    regCheck(4'd8, 16'd1, "R3");
    // write masks R1 R2 R3
    regWrite(4'd0, 16'hFFFF); regCheck(4'd0, 16'h03FF, "R1");
    regWrite(4'd2, 16'hFFFF); regCheck(4'd2, 16'h03FF, "R1");
    regWrite(4'd4, 16'hFFFF); regCheck(4'd4, 16'h83FF, "R1");
    regWrite(4'd1, 16'hFFFF); regCheck(4'd1, 16'hFFE0, "R2");
    regWrite(4'd3, 16'hFFFF); regCheck(4'd3, 16'hFFE0, "R2");
    regWrite(4'd6, 16'hFFFF); regCheck(4'd6, 16'h007F, "R3");
    regWrite(4'd7, 16'hFFFF); regCheck(4'd7, 16'h07FF, "R3");
    regWrite(4'd8, 16'h1234); regCheck(4'd8, 16'h0001, "R3");

    // main -> aux, 64 bytes (R5 R6)
    launch(26'h000_1000, 26'h000_2000, 64, 1'b0, 4'd0, 1'b1, "R5");
    waitDone(2 * 246, "R5");
    regCheck(4'd5, 16'h0040, "R2");

    // aux -> main, main address wraps at 64 MB (R6)
    launch(26'h3FF_FFE0, 26'h000_0040, 64, 1'b1, 4'd0, 1'b1, "R6");
    waitDone(2 * 246, "R6");

    // mirror mode crossing the boundary (R8)
    launch(26'h000_0800, 26'h03F_FFE0, 64, 1'b0, 4'd4, 1'b1, "R8");
    waitDone(2 * 246, "R8");

    // mirror info but aux -> main: no extra writes (R8)
    launch(26'h000_0400, 26'h000_0100, 32, 1'b1, 4'd4, 1'b1, "R8");
    waitDone(246, "R8");

    // aux start beyond configured size: no beats (R9)
    launch(26'h000_0000, 26'h200_0000, 64, 1'b0, 4'd0, 1'b0, "R9");
    waitDone(2 * 246, "R9");

    // zero length (R7)
    launch(26'h000_0000, 26'h000_0000, 0, 1'b0, 4'd0, 1'b1, "R7");
    waitDone(2, "R7");

    // start while busy is ignored (R10)
    launch(26'h000_3000, 26'h000_5000, 32, 1'b0, 4'd0, 1'b1, "R10");
    regWrite(4'd5, 16'h0100);
    regCheck(4'd5, 16'h0020, "R10");
    waitDone(246, "R10");
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && expQ.size() == 0, "R10", "no restart", 64'(busy), 64'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule